// File: doc/BRIEF.md
# Bus Status Cycle Decoder

This block watches the 3-bit encoded bus status that a processor drives when it shares its local bus with other masters. The status is sampled once per clock. From its transitions alone (leaving the passive code opens a cycle, coming back to it closes one) the block reports the kind of transfer in progress as a one-hot class, a one-clock start pulse, a one-clock end pulse and a busy flag that covers the data phase. No strobes are used to find the cycle boundaries.

A sticky protocol error flag catches two cases. The first is a status that jumps from one active code to a different active code without passing through passive. The second is a status that returns to passive while READY, sampled at the same edge, is low. As a side output, the 2-bit queue status is decoded into one-hot queue operation flags, one clock after it is sampled.

Top module: `bus_status_decoder`

## Requirements
- R1: The class output is one-hot. The bit index equals the status code: 0 interrupt acknowledge, 1 I/O read, 2 I/O write, 3 halt, 4 code fetch, 5 memory read, 6 memory write. Code 7 is passive and maps to no bit.
- R2: `start_o` is high for exactly one clock: the clock after the edge where an active code is first sampled following a sampled passive code.
- R3: `cls_o` shows the class of the opening code from the start clock through the end clock. It shows zero outside a cycle. A later, different active code does not change it.
- R4: `end_o` is high for exactly one clock: the clock after the edge where passive is first sampled following an active code.
- R5: `busy_o` is high from the start clock up to the clock before the end clock, and low in the end clock. A cycle opened by the halt code never raises `busy_o`.
- R6: A sampled change from one active code directly to a different active code sets `proto_err_o` one clock after it is seen. The flag stays set until reset.
- R7: A return to passive sampled while READY is low also sets the sticky error, unless the cycle was a halt.
- R8: Holding the same active code for several clocks (for example during wait states) raises neither a new start nor an error.
- R9: `qop_o` decodes the queue status sampled at the last edge: 01 sets bit 0 (first opcode byte), 10 sets bit 1 (queue flushed), 11 sets bit 2 (later byte), and 00 sets none.
- R10: While reset is held, `cls_o`, `start_o`, `end_o`, `busy_o`, `proto_err_o` and `qop_o` are all zero, and the status history is treated as passive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| status_i | input | 3 | Encoded bus status from the processor |
| ready_i | input | 1 | Transfer ready from the addressed device |
| qstat_i | input | 2 | Encoded instruction queue status |
| cls_o | output | 7 | One-hot class of the current bus cycle |
| start_o | output | 1 | One-clock pulse at cycle start |
| end_o | output | 1 | One-clock pulse at cycle end |
| busy_o | output | 1 | Data phase in progress |
| proto_err_o | output | 1 | Sticky status protocol error |
| qop_o | output | 3 | One-hot queue operation |

## Verification
The bench targets the following corner cases:
- Wait states that hold one active code for several clocks. A decoder that treats every sampled active code as a start would pulse `start_o` repeatedly.
- A halt cycle. A design that forgets to exempt it would raise `busy_o`, or flag an error when the halt ends with READY low.
- Back-to-back cycles separated by a single passive clock. These expose a `cls_o` that is not cleared at the end, or a busy flag that does not drop in the end clock.
- Separate runs that make a direct active-to-active jump and a passive return with READY low. They check that the error flag is set one clock late, stays set, and leaves the held class unchanged.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  localparam int unsigned STAT_W    = 3;
  localparam int unsigned QS_W      = 2;
  localparam logic [STAT_W-1:0] STAT_HALT = 3'd3;
  localparam logic [STAT_W-1:0] STAT_IDLE = '1;

  typedef struct packed {
    logic open_c;
    logic close_c;
    logic fault;
  } bsd_evt_t;
endpackage

// File: rtl/bsd_sampler.sv
module bsd_sampler #(
  parameter int unsigned W     = 3,
  parameter int unsigned DEPTH = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [W-1:0]              d_i,
  output logic [DEPTH-1:0][W-1:0]   tap_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     tap_o[g] <= RST_VAL;
      else if (g == 0) tap_o[g] <= d_i;
      else             tap_o[g] <= tap_o[(g == 0) ? 0 : g-1];
    end
  end
endmodule

// File: rtl/bsd_edge_detect.sv
module bsd_edge_detect
  import bsd_pkg::*;
#(
  parameter int unsigned W = STAT_W,
  parameter logic [W-1:0] HALT_CODE = STAT_HALT
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] prv_i,
  input  logic         rdy_i,
  output bsd_evt_t     evt_o
);
  localparam logic [W-1:0] IDLE = '1;
  logic cur_act, prv_act, swap, late;

  always_comb begin
    cur_act       = (cur_i != IDLE);
    prv_act       = (prv_i != IDLE);
    evt_o.open_c  = !prv_act && cur_act;
    evt_o.close_c = prv_act && !cur_act;
    swap          = prv_act && cur_act && (cur_i != prv_i);
    // passive return must be accompanied by ready, halt exempt
    late          = evt_o.close_c && !rdy_i && (prv_i != HALT_CODE);
    evt_o.fault   = swap || late;
  end
endmodule

// File: rtl/bsd_tracker.sv
module bsd_tracker
  import bsd_pkg::*;
#(
  parameter int unsigned W = STAT_W,
  parameter logic [W-1:0] HALT_CODE = STAT_HALT,
  localparam int unsigned NCLS = (1 << W) - 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  bsd_evt_t        evt_i,
  input  logic [W-1:0]    cur_i,
  output logic [NCLS-1:0] cls_o,
  output logic            busy_o,
  output logic            err_o
);
  logic [NCLS-1:0] cur_oh, cls_q;
  logic            busy_q;

  for (genvar g = 0; g < NCLS; g++) begin : g_oh
    assign cur_oh[g] = (cur_i == W'(g));
  end

  assign cls_o  = evt_i.open_c ? cur_oh : cls_q;
  assign busy_o = (evt_i.open_c && (cur_i != HALT_CODE)) || (busy_q && !evt_i.close_c);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cls_q  <= '0;
      busy_q <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      if (evt_i.open_c)       cls_q <= cur_oh;
      else if (evt_i.close_c) cls_q <= '0;
      busy_q <= busy_o;
      err_o  <= err_o | evt_i.fault;
    end
  end

  // R1
  cls_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(cls_o));
  // R2
  start_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.open_c |=> !evt_i.open_c);
  // R4
  end_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.close_c |=> !evt_i.close_c);
  // R5
  halt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i.open_c && cur_i == HALT_CODE) |-> !busy_o);
  // R5
  busy_cont_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !evt_i.close_c) |=> (busy_o || evt_i.close_c));
  // R3
  cls_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !evt_i.close_c) |=> $stable(cls_o));
  // R6
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) err_o |=> err_o);
endmodule

// File: rtl/bsd_qdec.sv
module bsd_qdec
  import bsd_pkg::*;
#(
  parameter int unsigned W = QS_W,
  localparam int unsigned NOP = (1 << W) - 1
) (
  input  logic [W-1:0]   qs_i,
  output logic [NOP-1:0] qop_o
);
  for (genvar g = 0; g < NOP; g++) begin : g_dec
    assign qop_o[g] = (qs_i == W'(g + 1));
  end

  // R9
  always_comb begin
    qop_onehot_chk: assert ($onehot0(qop_o));
  end
endmodule

// File: rtl/bus_status_decoder.sv
module bus_status_decoder
  import bsd_pkg::*;
#(
  parameter int unsigned SW = STAT_W,
  parameter int unsigned QW = QS_W,
  parameter logic [SW-1:0] HALT_CODE = STAT_HALT
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [SW-1:0]          status_i,
  input  logic                   ready_i,
  input  logic [QW-1:0]          qstat_i,
  output logic [(1<<SW)-2:0]     cls_o,
  output logic                   start_o,
  output logic                   end_o,
  output logic                   busy_o,
  output logic                   proto_err_o,
  output logic [(1<<QW)-2:0]     qop_o
);
  logic [1:0][SW-1:0] st_tap;
  logic [0:0][0:0]    rdy_tap;
  logic [0:0][QW-1:0] qs_tap;
  bsd_evt_t           evt;

  bsd_sampler #(.W(SW), .DEPTH(2), .RST_VAL('1)) u_st_smp (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(status_i), .tap_o(st_tap));

  bsd_sampler #(.W(1), .DEPTH(1), .RST_VAL(1'b1)) u_rdy_smp (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ready_i), .tap_o(rdy_tap));

  bsd_sampler #(.W(QW), .DEPTH(1), .RST_VAL('0)) u_qs_smp (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(qstat_i), .tap_o(qs_tap));

  bsd_edge_detect #(.W(SW), .HALT_CODE(HALT_CODE)) u_edge (
    .cur_i(st_tap[0]), .prv_i(st_tap[1]), .rdy_i(rdy_tap[0][0]), .evt_o(evt));

  bsd_tracker #(.W(SW), .HALT_CODE(HALT_CODE)) u_trk (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt), .cur_i(st_tap[0]),
    .cls_o(cls_o), .busy_o(busy_o), .err_o(proto_err_o));

  bsd_qdec #(.W(QW)) u_qdec (.qs_i(qs_tap[0]), .qop_o(qop_o));

  assign start_o = evt.open_c;
  assign end_o   = evt.close_c;

  // R4
  start_end_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !(start_o && end_o));
endmodule

// File: tb/bus_status_decoder_tb.sv
module bus_status_decoder_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] status_i = 3'd7;
  logic       ready_i = 1'b1;
  logic [1:0] qstat_i = 2'd0;
  logic [6:0] cls_o;
  logic       start_o, end_o, busy_o, proto_err_o;
  logic [2:0] qop_o;

  int checks = 0, errors = 0;
  int m_cur, m_prv, m_cls, m_qs;
  bit m_rdy, m_busy, m_err;

  always #10 clk = ~clk;

  bus_status_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .status_i(status_i), .ready_i(ready_i),
    .qstat_i(qstat_i), .cls_o(cls_o), .start_o(start_o), .end_o(end_o),
    .busy_o(busy_o), .proto_err_o(proto_err_o), .qop_o(qop_o));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cur = 7; m_prv = 7; m_cls = -1; m_qs = 0;
    m_rdy = 1; m_busy = 0; m_err = 0;
  endtask

  // R10: reset state
  task automatic do_reset();
    rst_ni = 1'b0; status_i = 3'd7; ready_i = 1'b1; qstat_i = 2'd0;
    model_reset();
    repeat (2) @(negedge clk);
    chk("R10 cls", int'(cls_o), 0);
    chk("R10 start", int'(start_o), 0);
    chk("R10 end", int'(end_o), 0);
    chk("R10 busy", int'(busy_o), 0);
    chk("R10 err", int'(proto_err_o), 0);
    chk("R10 qop", int'(qop_o), 0);
    rst_ni = 1'b1;
  endtask

  task automatic step(input int st, input bit rdy, input int qs);
    bit s, e, bexp;
    int cexp, qexp;
    status_i = 3'(st); ready_i = rdy; qstat_i = 2'(qs);
    @(posedge clk);
    m_prv = m_cur; m_cur = st; m_rdy = rdy; m_qs = qs;
    @(negedge clk);
    s = (m_prv == 7) && (m_cur != 7);
    e = (m_prv != 7) && (m_cur == 7);
    if (s) m_cls = m_cur;
    cexp = (m_cls >= 0) ? (1 << m_cls) : 0;
    bexp = (s && m_cur != 3) || (m_busy && !e);
    qexp = (m_qs == 0) ? 0 : (1 << (m_qs - 1));
    chk("R2 R8 start", int'(start_o), int'(s));
    chk("R4 end", int'(end_o), int'(e));
    chk("R1 R3 cls", int'(cls_o), cexp);
    chk("R5 busy", int'(busy_o), int'(bexp));
    chk("R6 R7 err", int'(proto_err_o), int'(m_err));
    chk("R9 qop", int'(qop_o), qexp);
    if (e) m_cls = -1;
    m_busy = bexp;
    if ((m_prv != 7 && m_cur != 7 && m_prv != m_cur) || (e && !m_rdy && m_prv != 3))
      m_err = 1'b1;
  endtask

  task automatic cycle(input int code, input int act_clks);
    for (int i = 0; i < act_clks; i++) step(code, (i == act_clks - 1), i % 4);
    step(7, 1'b1, 0);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk);
    do_reset();
    repeat (3) step(7, 1'b1, 0);
    // R1 R2 R3 R4 R5: every code as a plain three-clock cycle
    for (int c = 0; c < 7; c++) begin
      cycle(c, 3);
      step(7, 1'b1, 3);
    end
    // R8: wait states hold one code with ready low
    step(2, 1'b1, 1); step(2, 1'b1, 2);
    for (int i = 0; i < 4; i++) step(2, 1'b0, 3);
    step(2, 1'b1, 0);
    step(7, 1'b1, 0);
    // back-to-back cycles with one passive clock between
    cycle(6, 3); cycle(4, 2); cycle(5, 1);
    // R7 exemption: halt ends with ready low, no error
    step(3, 1'b1, 0); step(3, 1'b1, 0); step(7, 1'b0, 0); step(7, 1'b1, 0);
    chk("R7 halt exempt", int'(proto_err_o), 0);
    // R7: memory read returns to passive with ready low
    step(5, 1'b1, 0); step(5, 1'b1, 0); step(7, 1'b0, 0); step(7, 1'b1, 0);
    chk("R7 late ready", int'(proto_err_o), 1);
    repeat (2) step(7, 1'b1, 0);
    do_reset();
    // R6: direct active-to-active jump, class kept from first code
    step(7, 1'b1, 0); step(1, 1'b1, 0); step(6, 1'b1, 0);
    chk("R3 class kept", int'(cls_o), 2);
    step(6, 1'b1, 0); step(7, 1'b1, 0);
    chk("R6 sticky", int'(proto_err_o), 1);
    cycle(4, 3);
    do_reset();
    step(7, 1'b1, 2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule